// File: doc/BRIEF.md
# I2C Target Interface with Clock Stretching

This block is the bus-side engine of an I2C target (slave). It oversamples the bus clock and data lines with the system clock. It finds start, repeated start and stop conditions. It compares the address phase against a configured own address, either in 7-bit form or in the two-byte 10-bit form, and drives an acknowledge only when the address matches. Write bytes from the controller reach the host as a one-cycle strobe with the byte. Read bytes are taken from a host data input at the start of each byte.

The bus lines are driven only through open-drain enables. An enable of 1 pulls the line low, and an enable of 0 releases it. Once the target has accepted the first address byte, it can hold the clock line low for a configured number of system cycles after every falling clock edge. It places its next data or acknowledge level on the data line in the same cycle it lets the clock go. A length of zero turns stretching off.

Top module: `i2c_target`

## Requirements
- R1: After reset, `scl_oe`, `sda_oe`, `rx_valid` and `tx_taken` are all 0.
- R2: With `cfg_ten`=0, the address byte is the seven bits `cfg_addr[6:0]` (MSB first) followed by a direction bit, where 1 means read. On a match the target pulls SDA low during the ninth clock. On a mismatch it leaves SDA released.
- R3: With `cfg_ten`=1, the first address byte must be binary 11110, then `cfg_addr[9:8]`, then the direction bit. The second byte must equal `cfg_addr[7:0]`. Each matching byte is acknowledged, and a mismatch in either byte is not acknowledged. The direction bit of the first byte selects read or write after the second byte.
- R4: In a write transfer, each byte is shifted in MSB first on SCL rising edges. It is delivered on `rx_data` with a one-cycle `rx_valid` pulse at the SCL fall that ends bit 0, and then acknowledged.
- R5: In a read transfer, `tx_data` is captured with a one-cycle `tx_taken` pulse at the start of each byte. The byte is driven MSB first while SCL is low, and SDA is released during the ninth clock.
- R6: A controller ACK (SDA 0 on the ninth clock) continues the read with the next byte. A NACK (1) ends it: the target drives neither line and fetches no further byte until the next start or stop.
- R7: A start is an SDA fall while SCL is high, and a stop is an SDA rise while SCL is high. A repeated start during a transfer restarts the address phase, and a stop returns the target to idle with both lines released.
- R8: When `cfg_stretch`=N>0 and the target is engaged (from the first address acknowledge on), each SCL fall is followed by exactly N cycles of `scl_oe`=1. With N=0, `scl_oe` never asserts.
- R9: The next SDA level is applied in the same cycle that the stretch ends, so the bit is valid when SCL first reads high. Without stretching, it is applied one cycle after the SCL fall is seen.
- R10: After driving an acknowledge, the target releases SDA at the next SCL fall, so the controller reads back its own bits.
- R11: After an address mismatch, the target drives neither SDA nor SCL and delivers no byte until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversampling the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| scl_oe | output | 1 | 1 pulls the bus clock low (stretch) |
| sda_oe | output | 1 | 1 pulls the bus data low |
| cfg_addr | input | 10 | Own address; bits 6:0 used in 7-bit mode |
| cfg_ten | input | 1 | 1 selects 10-bit addressing |
| cfg_stretch | input | 8 | Stretch length in clk cycles, 0 = off |
| rx_data | output | 8 | Last byte written by the controller |
| rx_valid | output | 1 | One-cycle strobe for `rx_data` |
| tx_data | input | 8 | Byte to send on the next read byte |
| tx_taken | output | 1 | One-cycle strobe when `tx_data` is captured |

## Verification
Two things meet in one cycle: the end of a clock stretch and the presentation of the next data bit. Both are decided from the same SCL fall, and each is released by its own register. The bench provokes this by running a read with a stretch of 40 cycles, which is longer than the controller's own low time. The bench controller then waits for SCL to read high and samples SDA in that first high cycle. That early sample must equal the value sampled in mid-high, and the measured length of every stretch must equal the configured one.

// File: rtl/i2ct_pkg.sv
`timescale 1ns/1ps
// Shared types and constants for the I2C target.
// Assumes byte-wide transfers with a ninth acknowledge clock.
package i2ct_pkg;
    localparam int          BYTE_W    = 8;
    localparam int          BITC_W    = 4;
    localparam logic [3:0]  ACK_SLOT  = 4'd8;
    localparam logic [4:0]  TEN_HDR   = 5'b11110;

    typedef enum logic [2:0] {
        ST_IDLE,   // bus free or not yet started
        ST_ADR1,   // first (or only) address byte
        ST_ADR2,   // second 10-bit address byte
        ST_RX,     // controller writes data
        ST_TX,     // controller reads data
        ST_HOLD    // not addressed / read ended: stay off the bus
    } tgt_state_e;
endpackage

// File: rtl/i2ct_sync.sv
`timescale 1ns/1ps
// Multi-stage synchronizer for asynchronous bus lines.
// Assumes STAGES >= 2; resets to the released (high) bus level.
module i2ct_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_line
        logic [STAGES-1:0] chain;
        // Shift the raw level through the flop chain.
        always_ff @(posedge clk) begin
            if (!rst_n) chain <= '1;
            else        chain <= {chain[STAGES-2:0], d[i]};
        end
        assign q[i] = chain[STAGES-1];
    end
endmodule

// File: rtl/i2ct_busmon.sv
`timescale 1ns/1ps
// Detects SCL edges and start/stop conditions on synchronized lines.
// Assumes both inputs already come out of a synchronizer.
module i2ct_busmon (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev
);
    logic scl_p, sda_p;

    // Remember last sample of each line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_p <= scl_s;
            sda_p <= sda_s;
        end
    end

    assign scl_rise = !scl_p && scl_s;
    assign scl_fall = scl_p && !scl_s;
    assign start_ev = scl_p && scl_s && sda_p && !sda_s;
    assign stop_ev  = scl_p && scl_s && !sda_p && sda_s;
endmodule

// File: rtl/i2ct_stretch.sv
`timescale 1ns/1ps
// Down-counter that holds SCL low for a loaded number of cycles.
// 'last' flags the final held cycle (or no hold at all).
module i2ct_stretch #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             load,
    input  logic [CNT_W-1:0] len,
    output logic             hold,
    output logic             last
);
    logic [CNT_W-1:0] cnt_q;

    // Load on request, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)     cnt_q <= '0;
        else if (load)         cnt_q <= len;
        else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
    end

    assign hold = (cnt_q != '0);
    assign last = (cnt_q <= CNT_W'(1));

    // R8: with a zero length configured, an idle timer stays idle
    p_zero_len_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (len == '0 && !hold) |=> !hold);
endmodule

// File: rtl/i2c_target.sv
`timescale 1ns/1ps
// I2C target: address match (7/10-bit), byte receive/transmit,
// optional clock stretching. Assumes clk is much faster than SCL
// and that the lines are wired-AND with external pull-ups.
module i2c_target
    import i2ct_pkg::*;
#(
    parameter int ADDR_W    = 10,
    parameter int STRETCH_W = 8,
    parameter int SYNC_N    = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 scl_i,
    input  logic                 sda_i,
    output logic                 scl_oe,
    output logic                 sda_oe,
    input  logic [ADDR_W-1:0]    cfg_addr,
    input  logic                 cfg_ten,
    input  logic [STRETCH_W-1:0] cfg_stretch,
    output logic [BYTE_W-1:0]    rx_data,
    output logic                 rx_valid,
    input  logic [BYTE_W-1:0]    tx_data,
    output logic                 tx_taken
);
    logic scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;
    logic st_hold, st_last;

    tgt_state_e          state_q, state_d;
    logic [BITC_W-1:0]   bit_q, bit_d;
    logic [BYTE_W-1:0]   sh_q, sh_d, rxd_q, rxd_d;
    logic                rw_q, rw_d, nack_q, nack_d, rxv_d, txt_d;
    logic                hi_q, pend_q, sda_oe_q, rxv_q, txt_q;
    logic                fall_ok, match1, engaged_d, sda_want, st_load;

    i2ct_sync #(.WIDTH(2), .STAGES(SYNC_N)) u_sync (
        .clk(clk), .rst_n(rst_n), .d({scl_i, sda_i}), .q({scl_s, sda_s}));

    i2ct_busmon u_mon (
        .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_ev(start_ev), .stop_ev(stop_ev));

    i2ct_stretch #(.CNT_W(STRETCH_W)) u_str (
        .clk(clk), .rst_n(rst_n), .clr(start_ev || stop_ev),
        .load(st_load), .len(cfg_stretch), .hold(st_hold), .last(st_last));

    assign fall_ok = scl_fall && hi_q &&
                     (state_q inside {ST_ADR1, ST_ADR2, ST_RX, ST_TX});
    assign match1  = cfg_ten ? (sh_q[7:3] == TEN_HDR && sh_q[2:1] == cfg_addr[9:8])
                             : (sh_q[7:1] == cfg_addr[6:0]);

    // Next-state logic: conditions, bit sampling and byte boundaries.
    always_comb begin
        state_d = state_q; bit_d = bit_q; sh_d = sh_q; rw_d = rw_q;
        nack_d = nack_q; rxd_d = rxd_q; rxv_d = 1'b0; txt_d = 1'b0;
        if (start_ev) begin
            state_d = ST_ADR1; bit_d = '0; nack_d = 1'b0;
        end else if (stop_ev) begin
            state_d = ST_IDLE; bit_d = '0;
        end else if (scl_rise) begin
            if (state_q inside {ST_ADR1, ST_ADR2, ST_RX} && bit_q < ACK_SLOT)
                sh_d = {sh_q[BYTE_W-2:0], sda_s};
            if (state_q == ST_TX && bit_q == ACK_SLOT)
                nack_d = sda_s;
        end else if (fall_ok) begin
            if (bit_q == ACK_SLOT - 1) begin
                bit_d = ACK_SLOT;
                case (state_q)
                    ST_ADR1: if (match1) rw_d = sh_q[0]; else state_d = ST_HOLD;
                    ST_ADR2: if (sh_q != cfg_addr[7:0]) state_d = ST_HOLD;
                    ST_RX:   begin rxv_d = 1'b1; rxd_d = sh_q; end
                    default: ;
                endcase
            end else if (bit_q == ACK_SLOT) begin
                bit_d = '0;
                if ((state_q == ST_ADR1 && cfg_ten) || state_q == ST_RX) begin
                    state_d = (state_q == ST_RX) ? ST_RX : ST_ADR2;
                end else if (state_q == ST_TX && nack_q) begin
                    state_d = ST_HOLD;
                end else if (state_q == ST_TX || rw_q) begin
                    state_d = ST_TX; sh_d = tx_data; txt_d = 1'b1;
                end else begin
                    state_d = ST_RX;
                end
            end else begin
                bit_d = BITC_W'(bit_q + 1'b1);
                if (state_q == ST_TX) sh_d = {sh_q[BYTE_W-2:0], 1'b1};
            end
        end
    end

    assign engaged_d = (state_d inside {ST_ADR2, ST_RX, ST_TX}) ||
                       (state_d == ST_ADR1 && bit_d == ACK_SLOT);
    assign st_load   = fall_ok && engaged_d && (cfg_stretch != '0);
    assign sda_want  = (bit_q == ACK_SLOT && state_q inside {ST_ADR1, ST_ADR2, ST_RX}) ||
                       (state_q == ST_TX && bit_q < ACK_SLOT && !sh_q[BYTE_W-1]);

    // State registers and strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE; bit_q <= '0; sh_q <= '1; rw_q <= 1'b0;
            nack_q <= 1'b0; rxd_q <= '0; rxv_q <= 1'b0; txt_q <= 1'b0;
            hi_q <= 1'b0;
        end else begin
            state_q <= state_d; bit_q <= bit_d; sh_q <= sh_d; rw_q <= rw_d;
            nack_q <= nack_d; rxd_q <= rxd_d; rxv_q <= rxv_d; txt_q <= txt_d;
            if (start_ev || scl_fall) hi_q <= 1'b0;
            else if (scl_rise)        hi_q <= 1'b1;
        end
    end

    // Present the next SDA level once the stretch (if any) ends.
    always_ff @(posedge clk) begin
        if (!rst_n || start_ev || stop_ev) begin
            pend_q <= 1'b0; sda_oe_q <= 1'b0;
        end else if (fall_ok) begin
            pend_q <= 1'b1;
        end else if (pend_q && st_last) begin
            pend_q <= 1'b0; sda_oe_q <= sda_want;
        end
    end

    assign scl_oe   = st_hold;
    assign sda_oe   = sda_oe_q;
    assign rx_data  = rxd_q;
    assign rx_valid = rxv_q;
    assign tx_taken = txt_q;

    // R11: an unaddressed or finished target stays off both lines
    p_quiet_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD) |-> (!sda_oe_q && !scl_oe));
    // R9: SDA drive only changes while the sampled clock is low
    p_sda_change_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe_q) |-> !$past(scl_s));
    // R4: a received byte is reported before its acknowledge is driven
    p_rx_before_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> !sda_oe_q);
    // R5: SDA is released in the controller's acknowledge slot
    p_tx_ack_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_TX && bit_q == ACK_SLOT && !pend_q) |-> !sda_oe_q);
    // R8: a stretch only begins together with a pending bit
    p_stretch_with_bit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scl_oe) |-> pend_q);
endmodule

// File: tb/i2c_target_tb.sv
`timescale 1ns/1ps
module i2c_target_tb;
    localparam int Q = 20;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst_n = 1'b0, scl_m = 1'b1, sda_m = 1'b1;
    logic scl_oe, sda_oe, scl_bus, sda_bus, rx_valid, tx_taken, cfg_ten;
    logic [9:0] cfg_addr;
    logic [7:0] cfg_stretch, rx_data, tx_data;
    logic [7:0] tx_mem [4];
    int tx_idx = 0;

    assign scl_bus = scl_m & ~scl_oe;
    assign sda_bus = sda_m & ~sda_oe;
    assign tx_data = tx_mem[tx_idx & 3];

    i2c_target u_dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_bus), .sda_i(sda_bus),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .cfg_addr(cfg_addr), .cfg_ten(cfg_ten),
        .cfg_stretch(cfg_stretch), .rx_data(rx_data), .rx_valid(rx_valid),
        .tx_data(tx_data), .tx_taken(tx_taken));

    int n_chk = 0, n_fail = 0;
    logic [7:0] exp_rx [$];
    int run = 0, smin = 0, smax = 0, scnt = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    // Scoreboard monitor: pops expected write bytes, feeds read bytes.
    always @(negedge clk) begin
        if (rst_n && rx_valid) begin
            if (exp_rx.size() == 0) chk(1'b0, "R11 unexpected byte", rx_data, 0);
            else begin
                automatic logic [7:0] e = exp_rx.pop_front();
                chk(rx_data == e, "R4 received byte", rx_data, e);
            end
        end
        if (rst_n && tx_taken) tx_idx <= tx_idx + 1;
    end

    // Stretch length monitor.
    always @(negedge clk) begin
        if (scl_oe) run++;
        else if (run > 0) begin
            if (scnt == 0 || run < smin) smin = run;
            if (run > smax) smax = run;
            scnt++;
            run = 0;
        end
    end

    task automatic wq(input int n); repeat (n) @(negedge clk); endtask
    task automatic clr_stats(); scnt = 0; smin = 0; smax = 0; endtask
    task automatic wait_high(); while (!scl_bus) @(negedge clk); endtask

    task automatic ctl_start(); sda_m = 1'b0; wq(Q); scl_m = 1'b0; wq(Q); endtask
    task automatic ctl_rstart();
        sda_m = 1'b1; wq(Q); scl_m = 1'b1; @(negedge clk); wait_high(); wq(Q);
        sda_m = 1'b0; wq(Q); scl_m = 1'b0; wq(Q);
    endtask
    task automatic ctl_stop();
        sda_m = 1'b0; wq(Q); scl_m = 1'b1; @(negedge clk); wait_high(); wq(Q);
        sda_m = 1'b1; wq(Q);
    endtask

    task automatic ctl_bit(input logic b, output logic r, output logic early);
        sda_m = b; wq(Q); scl_m = 1'b1; @(negedge clk); wait_high();
        early = sda_bus; wq(Q); r = sda_bus; wq(Q); scl_m = 1'b0; wq(Q);
    endtask

    task automatic wr_byte(input logic [7:0] v, input logic exp_ack,
                           input bit is_data, input string req);
        logic r, e;
        int mism = 0;
        if (is_data && !exp_ack) exp_rx.push_back(v);
        for (int i = 7; i >= 0; i--) begin
            ctl_bit(v[i], r, e);
            if (r != v[i]) mism++;
        end
        chk(mism == 0, "R10 own bits read back (SDA released)", mism, 0);
        ctl_bit(1'b1, r, e);
        chk(r == exp_ack, req, r, exp_ack);
    endtask

    task automatic rd_byte(output logic [7:0] v, input logic ack_out, output int early_bad);
        logic r, e;
        early_bad = 0;
        for (int i = 7; i >= 0; i--) begin
            ctl_bit(1'b1, r, e);
            v = {v[6:0], r};
            if (e != r) early_bad++;
        end
        ctl_bit(ack_out, r, e);
    endtask

    initial begin
        logic [7:0] v;
        int eb;
        cfg_addr = 10'h02A; cfg_ten = 1'b0; cfg_stretch = 8'd0;
        tx_mem[0] = 8'hC3; tx_mem[1] = 8'h5A; tx_mem[2] = 8'h96; tx_mem[3] = 8'h0F;
        wq(10); rst_n = 1'b1; wq(2);
        chk(scl_oe == 0 && sda_oe == 0, "R1 lines released after reset", {scl_oe, sda_oe}, 0);
        chk(rx_valid == 0 && tx_taken == 0, "R1 strobes low after reset", {rx_valid, tx_taken}, 0);
        wq(Q);

        // 7-bit write, no stretch
        clr_stats(); ctl_start();
        wr_byte(8'h54, 1'b0, 0, "R2 7-bit write address ack");
        wr_byte(8'hA5, 1'b0, 1, "R4 data ack");
        wr_byte(8'h3C, 1'b0, 1, "R4 data ack");
        ctl_stop(); wq(4);
        chk(exp_rx.size() == 0, "R4 all bytes delivered", exp_rx.size(), 0);
        chk(scnt == 0, "R8 no stretch with zero length", scnt, 0);
        chk(scl_oe == 0 && sda_oe == 0, "R7 released after stop", {scl_oe, sda_oe}, 0);

        // 7-bit mismatch with stretch enabled
        cfg_stretch = 8'd30; clr_stats(); ctl_start();
        wr_byte(8'h56, 1'b1, 0, "R2 mismatch not acknowledged");
        wr_byte(8'h55, 1'b1, 1, "R11 ignored byte not acknowledged");
        ctl_stop(); wq(4);
        chk(scnt == 0, "R11 no stretch while ignoring", scnt, 0);

        // 7-bit read: ACK then NACK, then bus left alone
        cfg_stretch = 8'd0; tx_idx = 0; ctl_start();
        wr_byte(8'h55, 1'b0, 0, "R2 7-bit read address ack");
        rd_byte(v, 1'b0, eb); chk(v == 8'hC3, "R5 first read byte", v, 8'hC3);
        rd_byte(v, 1'b1, eb); chk(v == 8'h5A, "R6 byte after ACK", v, 8'h5A);
        chk(tx_idx == 2, "R5 one fetch per byte", tx_idx, 2);
        rd_byte(v, 1'b1, eb); chk(v == 8'hFF, "R6 SDA released after NACK", v, 8'hFF);
        chk(tx_idx == 2, "R6 no fetch after NACK", tx_idx, 2);
        ctl_stop(); wq(Q);

        // 10-bit write
        cfg_ten = 1'b1; cfg_addr = 10'h2D6; ctl_start();
        wr_byte(8'hF4, 1'b0, 0, "R3 first 10-bit byte ack");
        wr_byte(8'hD6, 1'b0, 0, "R3 second 10-bit byte ack");
        wr_byte(8'h81, 1'b0, 1, "R4 data ack in 10-bit mode");
        ctl_stop(); wq(Q);

        // 10-bit mismatch in low byte
        ctl_start();
        wr_byte(8'hF4, 1'b0, 0, "R3 first byte ack");
        wr_byte(8'hD7, 1'b1, 0, "R3 second byte mismatch");
        wr_byte(8'h11, 1'b1, 1, "R11 ignored after mismatch");
        ctl_stop(); wq(Q);

        // 10-bit mismatch in header bits 9:8
        ctl_start();
        wr_byte(8'hF2, 1'b1, 0, "R3 header mismatch");
        ctl_stop(); wq(Q);

        // Repeated start into a stretched 10-bit read
        cfg_stretch = 8'd40; clr_stats(); ctl_start();
        wr_byte(8'hF4, 1'b0, 0, "R3 first byte ack");
        wr_byte(8'hD6, 1'b0, 0, "R3 second byte ack");
        wr_byte(8'h7E, 1'b0, 1, "R4 data ack with stretch");
        ctl_rstart();
        wr_byte(8'hF5, 1'b0, 0, "R7 address ack after repeated start");
        wr_byte(8'hD6, 1'b0, 0, "R3 second byte ack for read");
        rd_byte(v, 1'b1, eb);
        chk(v == 8'h96, "R5 stretched read byte", v, 8'h96);
        chk(eb == 0, "R9 bit valid when SCL released", eb, 0);
        ctl_stop(); wq(4);
        chk(scnt > 0 && smin == 40 && smax == 40, "R8 stretch length 40", smax, 40);

        // 7-bit write with stretch
        cfg_ten = 1'b0; cfg_addr = 10'h02A; cfg_stretch = 8'd25; clr_stats(); ctl_start();
        wr_byte(8'h54, 1'b0, 0, "R2 address ack with stretch");
        wr_byte(8'hE7, 1'b0, 1, "R4 data ack with stretch");
        ctl_stop(); wq(4);
        chk(scnt > 0 && smin == 25 && smax == 25, "R8 stretch length 25", smin, 25);
        chk(exp_rx.size() == 0, "R4 scoreboard drained", exp_rx.size(), 0);

        report();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 200000, 0);
        report();
        $finish;
    end
endmodule